// File: doc/BRIEF.md
# Up-Counting Period Timer with Set/Reset Compare Output

This block is a free-running interval timer. A counter steps once per tick from zero up to a period value held in compare channel 0, then returns to zero on the following tick. A full period is therefore the period value plus one ticks long. A tick is the input clock divided by 1, 2, 4 or 8. Compare channel 0 drives an output pin that goes high on reaching the period value and low again at rollover. This gives a one-tick strobe at the end of every period, for example to start a converter. Compare channel 1 raises its own sticky flag at a programmable offset after rollover. It can also request its own interrupt, for example to fetch a result once a conversion is done.

All settings are loaded through a simple write port: a write strobe, a 3-bit register address and a data word. Period and offset values written while the timer runs are held in staging registers. They take effect only at the next rollover, so the period in progress always runs to its end. Writing the counter restarts the timing from the written value with a fresh prescaler phase.

Top module: `upcount_timer`

## Requirements
- R1: After reset the counter reads 0, the output pin, both flags and both interrupt requests are 0, and the timer is stopped.
- R2: While running (control bit 2 set), the counter advances by one per tick and, in the tick after it equals the period value (address 1), returns to 0; one period lasts period+1 ticks.
- R3: Control bits [1:0] select the tick as the clock divided by 2^sel (1, 2, 4, 8). No tick occurs while stopped, and a counter write clears the prescaler so that the first tick after it comes a full 2^sel clocks later.
- R4: The output pin goes high at the clock edge where the counter reaches the period value. It goes low at the edge where the counter rolls over to 0, so it stays high for one tick (2^sel clocks).
- R5: When output-enable (control bit 3) is clear, the output pin stays 0 while the counter and flags keep working.
- R6: The channel 1 flag is set at the edge where the counter reaches the offset value (address 2); an offset of 0 matches at rollover. The channel 0 flag is set when the counter reaches the period value. Interrupt request 1 is the channel 1 flag gated by control bit 4, and request 0 is the channel 0 flag gated by control bit 5; the two are independent.
- R7: Flags stay set until a write to address 4 clears them: data bit 0 clears the channel 0 flag, bit 1 the channel 1 flag. A write to address 4 with a bit at 0 leaves that flag unchanged.
- R8: Period and offset values written while running take effect at the next rollover; while stopped they take effect at once.
- R9: If the offset value is larger than the period value, channel 1 never matches and its flag stays clear.
- R10: A write to address 3 loads the counter with the written value, clears the output pin and restarts the timing from that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 period, 2 offset, 3 counter, 4 flag clear |
| wr_data | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current counter value |
| cmp_out | output | 1 | Set/reset compare output pin |
| flag0_o | output | 1 | Channel 0 (period) compare flag |
| flag1_o | output | 1 | Channel 1 (offset) compare flag |
| irq0 | output | 1 | Channel 0 interrupt request |
| irq1 | output | 1 | Channel 1 interrupt request |

## Verification
The bench builds the timer with the default 16-bit counter. It uses small period values so that every divider setting reaches several full periods within a short run. With these settings the edge cases are reachable: an offset of zero that matches at rollover, an offset beyond the period, a period cut by a shadowed write mid-period, and a restart landing just before a prescaler tick. Edge positions are predicted as multiples of 2^sel clocks from the run command and compared with the observed output, flags and counter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DIV_SEL_W = 2;
  localparam int PSC_W     = 3;
  localparam int CTRL_W    = 6;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_PERIOD = 3'd1,
    A_CMP1   = 3'd2,
    A_COUNT  = 3'd3,
    A_CLEAR  = 3'd4
  } reg_addr_e;

  localparam int B_RUN = 2;
  localparam int B_OE  = 3;
  localparam int B_IE1 = 4;
  localparam int B_IE0 = 5;

  // last prescaler phase for a divide-by-2^sel tick
  function automatic logic [PSC_W-1:0] psc_last(input logic [DIV_SEL_W-1:0] sel);
    return PSC_W'((32'd1 << sel) - 32'd1);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 restart,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 tick
);
  logic [PSC_W-1:0] phase_q;
  logic [PSC_W-1:0] last;
  logic             at_end;

  assign last   = psc_last(div_sel);
  assign at_end = (phase_q >= last);
  assign tick   = run && !restart && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) phase_q <= '0;
    else if (at_end)               phase_q <= '0;
    else                           phase_q <= phase_q + PSC_W'(1);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] per_stage,
  input  logic [CNT_W-1:0] cmp1_stage,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cmp1_act,
  output logic             wrap,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] per_nxt,
  output logic [CNT_W-1:0] cmp1_nxt
);
  logic load_shadow;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic rollover);
    return rollover ? '0 : c + CNT_W'(1);
  endfunction

  assign wrap        = tick && (cnt_q >= per_act);
  assign cnt_nxt     = step(cnt_q, wrap);
  assign load_shadow = !run || wrap;
  assign per_nxt     = load_shadow ? per_stage  : per_act;
  assign cmp1_nxt    = load_shadow ? cmp1_stage : cmp1_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      per_act  <= '1;
      cmp1_act <= '1;
    end else begin
      if (cnt_wr)    cnt_q <= cnt_wdata;
      else if (tick) cnt_q <= cnt_nxt;
      per_act  <= per_nxt;
      cmp1_act <= cmp1_nxt;
    end
  end
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] per_nxt,
  input  logic [CNT_W-1:0] cmp1_nxt,
  input  logic             clr0,
  input  logic             clr1,
  output logic             out_q,
  output logic             flag0,
  output logic             flag1
);
  logic ch0_hit;
  logic ch1_hit;

  assign ch0_hit = tick && (cnt_nxt == per_nxt);
  assign ch1_hit = tick && (cmp1_nxt <= per_nxt) && (cnt_nxt == cmp1_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      flag0 <= 1'b0;
      flag1 <= 1'b0;
    end else begin
      if (cnt_wr)    out_q <= 1'b0;
      else if (tick) out_q <= ch0_hit;
      // a new match wins over a simultaneous clear
      if (ch0_hit)   flag0 <= 1'b1;
      else if (clr0) flag0 <= 1'b0;
      if (ch1_hit)   flag1 <= 1'b1;
      else if (clr1) flag1 <= 1'b0;
    end
  end
endmodule

// File: rtl/upcount_timer.sv
module upcount_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cmp_out,
  output logic             flag0_o,
  output logic             flag1_o,
  output logic             irq0,
  output logic             irq1
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  per_stage, cmp1_stage;
  logic [CNT_W-1:0]  cnt_q, per_act, cmp1_act, cnt_nxt, per_nxt, cmp1_nxt;
  logic              run, oe, tick, wrap, cnt_wr, clr0, clr1;
  logic              out_q, flag0, flag1;

  assign run    = ctrl_q[B_RUN];
  assign oe     = ctrl_q[B_OE];
  assign cnt_wr = wr_en && (wr_addr == A_COUNT);
  assign clr0   = wr_en && (wr_addr == A_CLEAR) && wr_data[0];
  assign clr1   = wr_en && (wr_addr == A_CLEAR) && wr_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      per_stage  <= '1;
      cmp1_stage <= '1;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL)   ctrl_q     <= wr_data[CTRL_W-1:0];
      if (wr_addr == A_PERIOD) per_stage  <= wr_data;
      if (wr_addr == A_CMP1)   cmp1_stage <= wr_data;
    end
  end

  tmr_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(cnt_wr),
    .div_sel(ctrl_q[DIV_SEL_W-1:0]), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .cnt_wr(cnt_wr), .cnt_wdata(wr_data),
    .per_stage(per_stage), .cmp1_stage(cmp1_stage),
    .cnt_q(cnt_q), .per_act(per_act), .cmp1_act(cmp1_act), .wrap(wrap),
    .cnt_nxt(cnt_nxt), .per_nxt(per_nxt), .cmp1_nxt(cmp1_nxt)
  );

  tmr_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
    .cnt_nxt(cnt_nxt), .per_nxt(per_nxt), .cmp1_nxt(cmp1_nxt),
    .clr0(clr0), .clr1(clr1),
    .out_q(out_q), .flag0(flag0), .flag1(flag1)
  );

  assign cnt_o   = cnt_q;
  assign cmp_out = out_q && oe;
  assign flag0_o = flag0;
  assign flag1_o = flag1;
  assign irq0    = flag0 && ctrl_q[B_IE0];
  assign irq1    = flag1 && ctrl_q[B_IE1];
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             oe,
  input logic             tick,
  input logic             wrap,
  input logic             cnt_wr,
  input logic             clr0,
  input logic             clr1,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] per_act,
  input logic [CNT_W-1:0] per_nxt,
  input logic [CNT_W-1:0] cmp1_nxt,
  input logic             out_q,
  input logic             cmp_out,
  input logic             flag0,
  input logic             flag1
);
  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_q));
  // R4
  out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> (cnt_q == per_act));
  // R5
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !cmp_out);
  // R6
  flag1_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag1) |-> $past(tick));
  // R7
  flag0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag0 && !clr0) |=> flag0);
  // R7
  flag1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag1 && !clr1) |=> flag1);
  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(per_act));
  // R9
  far_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cmp1_nxt > per_nxt)) |=> !$rose(flag1));
  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> ((cnt_q == $past(wr_data)) && !out_q));
endmodule

bind upcount_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .oe(oe), .tick(tick), .wrap(wrap),
  .cnt_wr(cnt_wr), .clr0(clr0), .clr1(clr1), .cnt_q(cnt_q), .wr_data(wr_data),
  .per_act(per_act), .per_nxt(per_nxt), .cmp1_nxt(cmp1_nxt),
  .out_q(out_q), .cmp_out(cmp_out), .flag0(flag0), .flag1(flag1)
);

// File: tb/tb_upcount_timer.sv
`timescale 1ns/1ps
module tb_upcount_timer;
  import tmr_pkg::*;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt_o;
  logic         cmp_out, flag0_o, flag1_o, irq0, irq1;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #2.5 clk = ~clk;

  upcount_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt_o), .cmp_out(cmp_out), .flag0_o(flag0_o), .flag1_o(flag1_o),
    .irq0(irq0), .irq1(irq1)
  );

  // stimulus table: divider select, period, channel 1 offset
  localparam int NV = 5;
  localparam int V_SEL [NV] = '{0, 1, 2, 3, 0};
  localparam int V_PER [NV] = '{5, 3, 4, 2, 6};
  localparam int V_C1  [NV] = '{2, 0, 4, 1, 9};

  localparam int RUN = 1 << B_RUN;
  localparam int OE  = 1 << B_OE;
  localparam int IE1 = 1 << B_IE1;
  localparam int IE0 = 1 << B_IE0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input reg_addr_e a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int d, rise, fall, f0, f1, irq1_at, e_f1, k;
    bit irq0_seen, out_seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cnt_o == 0, "R1 counter", int'(cnt_o), 0);
    chk(!cmp_out && !flag0_o && !flag1_o, "R1 pin/flags", int'({cmp_out, flag0_o, flag1_o}), 0);
    chk(!irq0 && !irq1, "R1 irqs", int'({irq0, irq1}), 0);
    repeat (4) @(negedge clk);
    chk(cnt_o == 0, "R1 stopped", int'(cnt_o), 0);

    // table walk: R2 R3 R4 R6 R9
    for (int v = 0; v < NV; v++) begin
      d = 1 << V_SEL[v];
      rise = -1; fall = -1; f0 = -1; f1 = -1; irq1_at = 0; irq0_seen = 0;
      wr(A_CTRL, 0);
      wr(A_PERIOD, V_PER[v]);
      wr(A_CMP1, V_C1[v]);
      wr(A_COUNT, 0);
      wr(A_CLEAR, 3);
      wr(A_CTRL, V_SEL[v] | RUN | OE | IE1);
      for (int n = 1; n <= (V_PER[v] + 2) * d + 2; n++) begin
        @(negedge clk);
        if (cmp_out && rise < 0) rise = n;
        if (!cmp_out && rise >= 0 && fall < 0) fall = n;
        if (flag0_o && f0 < 0) f0 = n;
        if (flag1_o && f1 < 0) begin f1 = n; irq1_at = int'(irq1); end
        if (irq0) irq0_seen = 1;
      end
      if (V_C1[v] > V_PER[v])  e_f1 = -1;
      else if (V_C1[v] == 0)   e_f1 = (V_PER[v] + 1) * d;
      else                     e_f1 = V_C1[v] * d;
      chk(rise == V_PER[v] * d, "R4/R3 output rise clock", rise, V_PER[v] * d);
      chk(fall == (V_PER[v] + 1) * d, "R2/R4 rollover clock", fall, (V_PER[v] + 1) * d);
      chk(f0 == V_PER[v] * d, "R6 channel 0 flag clock", f0, V_PER[v] * d);
      if (e_f1 < 0) chk(f1 == -1, "R9 far offset never matches", f1, -1);
      else begin
        chk(f1 == e_f1, "R6 channel 1 flag clock", f1, e_f1);
        chk(irq1_at == 1, "R6 irq1 with enable", irq1_at, 1);
      end
      chk(!irq0_seen, "R6 irq0 off without its enable", int'(irq0_seen), 0);
    end

    // R5 output enable off, R6 irq0 enable
    wr(A_CTRL, 0);
    wr(A_PERIOD, 3);
    wr(A_COUNT, 0);
    wr(A_CLEAR, 3);
    wr(A_CTRL, RUN | IE0);
    out_seen = 0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (cmp_out) out_seen = 1;
    end
    chk(!out_seen, "R5 pin held low", int'(out_seen), 0);
    chk(flag0_o, "R5 compare still runs", int'(flag0_o), 1);
    chk(irq0 && !irq1, "R6 irq0 separate from irq1", int'({irq0, irq1}), 2);

    // R7 sticky flags
    wr(A_CTRL, 0);
    repeat (4) @(negedge clk);
    chk(flag0_o, "R7 flag stays set", int'(flag0_o), 1);
    wr(A_CLEAR, 2);
    chk(flag0_o, "R7 other bit leaves flag", int'(flag0_o), 1);
    wr(A_CLEAR, 1);
    chk(!flag0_o, "R7 clear bit 0", int'(flag0_o), 0);

    // R8 shadowed period
    wr(A_PERIOD, 9);
    wr(A_CMP1, 20);
    wr(A_COUNT, 0);
    wr(A_CLEAR, 3);
    wr(A_CTRL, RUN | OE);
    wr(A_PERIOD, 4);
    k = 0;
    while (!cmp_out && k < 30) begin @(negedge clk); k++; end
    chk(cnt_o == 9, "R8 running period kept", int'(cnt_o), 9);
    k = 0;
    do begin @(negedge clk); k++; end while (!(cmp_out && k > 1) && k < 40);
    chk(k == 5, "R8 new period after rollover", k, 5);

    // R10 / R3 restart with prescaler clear
    wr(A_CTRL, 0);
    wr(A_PERIOD, 20);
    wr(A_COUNT, 0);
    wr(A_CTRL, RUN | 2);
    repeat (5) @(negedge clk);
    wr(A_COUNT, 0);
    chk(cnt_o == 0, "R10 counter restarted", int'(cnt_o), 0);
    for (int j = 1; j <= 3; j++) begin
      @(negedge clk);
      chk(cnt_o == 0, "R3 full first tick after restart", int'(cnt_o), 0);
    end
    @(negedge clk);
    chk(cnt_o == 1, "R3 first tick after 4 clocks", int'(cnt_o), 1);
    wr(A_COUNT, 15);
    chk(cnt_o == 15, "R10 counter load", int'(cnt_o), 15);

    // R10 restart clears a high output
    wr(A_CTRL, 0);
    wr(A_PERIOD, 2);
    wr(A_COUNT, 0);
    wr(A_CTRL, RUN | OE);
    k = 0;
    while (!cmp_out && k < 10) begin @(negedge clk); k++; end
    wr_en = 1'b1; wr_addr = A_COUNT; wr_data = W'(2);
    @(negedge clk);
    wr_en = 1'b0;
    chk(!cmp_out, "R10 output cleared", int'(cmp_out), 0);
    chk(cnt_o == 2, "R10 loaded value", int'(cnt_o), 2);

    done = 1;
    summary();
    $finish;
  end
endmodule